// File: doc/BRIEF.md
# Galois Pseudo-Random Counter (4-bit)

This block is a small linear feedback shift register that serves as a fast counter when the order of the count values does not matter. It also serves as a cheap pseudo-random source. On each enabled clock the register shifts toward its most significant bit. When the bit leaving the top is 1, a fixed feedback mask is XORed into the shifted value. Each XOR has two inputs and none feeds another, so the timing path is one XOR and does not grow with width. With the default mask the register runs through all fifteen nonzero 4-bit values before it repeats.

A user can load a starting value (the seed) at any time. A zero seed is replaced with 0001, so the register can never enter the all-zero state, which would otherwise be a fixed point. A one-cycle wrap flag marks the moment the register returns by stepping to the most recently loaded seed. This makes one full period visible without an external comparator. The width and the feedback mask are parameters, and elaboration checks reject values that could lock up the register.

Top module: `lfsr_galois_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the register is set to 0001 after that edge, the stored seed becomes 0001, and `wrap` is 0.
- R2: On an enabled step, a register whose bit 3 is 0 simply shifts left (bit i takes bit i-1, bit 0 takes 0). When bit 3 is 1, the shifted value is XORed with 0011, which is the low four bits of the pattern 1_0011.
- R3: Starting from 0001 with `en` held high, the register takes the values 0001, 0010, 0100, 1000, 0011, 0110, 1100, 1011, 0101, 1010, 0111, 1110, 1111, 1101, 1001, and then 0001 again.
- R4: The period from any nonzero seed is exactly 15 steps, no value repeats within a period, and the register never holds 0000.
- R5: When `en` and `load` are both low, the register keeps its value and `wrap` is 0 on the following cycle.
- R6: When `load` is high at a rising edge, the register takes `seed` after that edge whatever `en` is. `load` takes priority over stepping, and `wrap` is 0 on the following cycle.
- R7: A load with `seed` equal to 0000 puts 0001 into the register and into the stored seed.
- R8: `wrap` is 1 for exactly the one cycle after an enabled step (with no load) whose new value equals the stored seed, and it is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load `seed` into the register (priority over `en`) |
| seed | input | WIDTH (4) | Starting value; 0 is replaced by 1 |
| state | output | WIDTH (4) | Current register value |
| wrap | output | 1 | One-cycle flag when stepping returns to the stored seed |

## Verification
The bench builds the block with its default parameters: WIDTH of 4 and a feedback mask of 0011. With these values the whole fifteen-value cycle is short enough to be listed as a table in the bench and compared one value at a time. With that width, one complete period from a seed that is not 0001 is also short enough to show that `wrap` fires only at the fifteenth step. Directed cases after the table cover the zero seed, a load while `en` is high, holding, and a reset during counting.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

   localparam int unsigned LFSR_WIDTH_DEF = 4;
   localparam logic [LFSR_WIDTH_DEF-1:0] LFSR_MASK_DEF = 4'b0011;

   // Action chosen for the state register in a given cycle, highest priority first.
   typedef enum logic [1:0] {
      ACT_RESET = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_STEP  = 2'd2,
      ACT_HOLD  = 2'd3
   } lfsr_act_e;

endpackage

// File: rtl/lfsr_galois_step.sv
module lfsr_galois_step #(
   parameter int unsigned WIDTH = 4,
   parameter logic [WIDTH-1:0] TAP_MASK = 4'b0011
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);

   localparam int unsigned TOP = WIDTH - 1;

   logic fb;
   assign fb = cur[TOP];

   // One cell per bit: either a plain shift or a single 2-input XOR.
   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic shifted;
      if (i == 0) begin : g_lsb
         assign shifted = 1'b0;
      end else begin : g_mid
         assign shifted = cur[i-1];
      end
      if (TAP_MASK[i]) begin : g_tap
         assign nxt[i] = shifted ^ fb;
      end else begin : g_plain
         assign nxt[i] = shifted;
      end
   end

   // A nonzero value must never step to zero (R4).
   always_comb begin
      if (cur != '0) begin
         assert_step_nonzero_R4: assert (nxt != '0 || $isunknown(cur));
      end
   end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] safe
);

   localparam logic [WIDTH-1:0] SUBST = WIDTH'(1);

   logic is_zero;
   assign is_zero = (raw == '0);
   assign safe    = is_zero ? SUBST : raw;

endmodule

// File: rtl/lfsr_galois_counter.sv
module lfsr_galois_counter
   import lfsr_pkg::*;
#(
   parameter int unsigned WIDTH = LFSR_WIDTH_DEF,
   parameter logic [WIDTH-1:0] TAP_MASK = LFSR_MASK_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] seed,
   output logic [WIDTH-1:0] state,
   output logic             wrap
);

   localparam logic [WIDTH-1:0] RESET_VAL = WIDTH'(1);
   localparam int unsigned      TOP       = WIDTH - 1;

   // Elaboration checks on the parameters.
   if (WIDTH < 2) begin : g_bad_width
      $error("lfsr_galois_counter: WIDTH must be at least 2");
   end
   if (!TAP_MASK[0]) begin : g_bad_mask
      $error("lfsr_galois_counter: TAP_MASK bit 0 must be set to avoid reaching zero");
   end

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] seed_q;
   logic [WIDTH-1:0] step_val;
   logic [WIDTH-1:0] seed_safe;
   logic             wrap_q;
   lfsr_act_e        act;

   lfsr_galois_step #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_step (
      .cur (state_q),
      .nxt (step_val)
   );

   lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
      .raw  (seed),
      .safe (seed_safe)
   );

   always_comb begin
      if (rst)       act = ACT_RESET;
      else if (load) act = ACT_LOAD;
      else if (en)   act = ACT_STEP;
      else           act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      unique case (act)
         ACT_RESET: begin
            state_q <= RESET_VAL;
            seed_q  <= RESET_VAL;
            wrap_q  <= 1'b0;
         end
         ACT_LOAD: begin
            state_q <= seed_safe;
            seed_q  <= seed_safe;
            wrap_q  <= 1'b0;
         end
         ACT_STEP: begin
            state_q <= step_val;
            wrap_q  <= (step_val == seed_q);
         end
         default: begin
            wrap_q  <= 1'b0;
         end
      endcase
   end

   assign state = state_q;
   assign wrap  = wrap_q;

   // Assertions guarding the register behaviour.
   assert_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
      state != '0);

   assert_shift_only_R2: assert property (@(posedge clk) disable iff (rst)
      (en && !load && !state[TOP]) |=> state == {$past(state[TOP-1:0]), 1'b0});

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!en && !load) |=> ($stable(state) && !wrap));

   assert_load_R6: assert property (@(posedge clk) disable iff (rst)
      (load && seed != '0) |=> (state == $past(seed) && !wrap));

   assert_zero_seed_R7: assert property (@(posedge clk) disable iff (rst)
      (load && seed == '0) |=> state == RESET_VAL);

   assert_wrap_cause_R8: assert property (@(posedge clk) disable iff (rst)
      wrap |-> ($past(en) && !$past(load) && state == seed_q));

endmodule

// File: tb/lfsr_galois_counter_tb_top.sv
module lfsr_galois_counter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W = 4;
   localparam int PERIOD = 15;
   localparam logic [W-1:0] SEQ [PERIOD] = '{
      4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
      4'b0110, 4'b1100, 4'b1011, 4'b0101, 4'b1010,
      4'b0111, 4'b1110, 4'b1111, 4'b1101, 4'b1001
   };

   logic clk = 1'b0;
   logic rst, en, load;
   logic [W-1:0] seed;
   logic [W-1:0] state;
   logic wrap;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_galois_counter dut_i (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .seed(seed), .state(state), .wrap(wrap)
   );

   task automatic chk(input string req, input logic [W-1:0] st_exp, input logic wr_exp);
      checks++;
      if (state !== st_exp || wrap !== wr_exp) begin
         failures++;
         $display("FAIL %s: state=%b wrap=%b expected state=%b wrap=%b",
                  req, state, wrap, st_exp, wr_exp);
      end
   endtask

   // Apply inputs at the falling edge, sample 1 time unit after the rising edge.
   task automatic cyc(input logic r, input logic e, input logic l, input logic [W-1:0] s);
      @(negedge clk);
      rst = r; en = e; load = l; seed = s;
      @(posedge clk);
      #1;
   endtask

   initial begin
      rst = 1'b1; en = 1'b0; load = 1'b0; seed = '0;
      cyc(1, 0, 0, 0);
      cyc(1, 1, 0, 4'b0110);
      chk("R1 reset", 4'b0001, 1'b0);

      // R3/R4/R8: table walk from 0001 over one full period.
      begin
         bit seen [16];
         for (int i = 0; i < 16; i++) seen[i] = 0;
         seen[1] = 1;
         for (int k = 1; k <= PERIOD; k++) begin
            cyc(0, 1, 0, 0);
            chk("R3 sequence", SEQ[k % PERIOD], (k == PERIOD));
            if (k < PERIOD) begin
               checks++;
               if (state == '0 || seen[state]) begin
                  failures++;
                  $display("FAIL R4 repeat/zero: state=%b expected new nonzero value", state);
               end
               seen[state] = 1;
            end
         end
      end

      // R2: step out of 1000 applies the mask; from 0100 a pure shift.
      cyc(0, 1, 0, 0);   // 0010
      cyc(0, 1, 0, 0);   // 0100
      cyc(0, 1, 0, 0);
      chk("R2 pure shift", 4'b1000, 1'b0);
      cyc(0, 1, 0, 0);
      chk("R2 feedback XOR", 4'b0011, 1'b0);

      // R5: hold with en low.
      for (int k = 0; k < 3; k++) begin
         cyc(0, 0, 0, 4'b1111);
         chk("R5 hold", 4'b0011, 1'b0);
      end

      // R6: load wins over en; then period from seed 1010 (index 9), R8 wrap at step 15.
      cyc(0, 1, 1, 4'b1010);
      chk("R6 load priority", 4'b1010, 1'b0);
      for (int j = 1; j <= PERIOD; j++) begin
         cyc(0, 1, 0, 0);
         chk("R8 period from seed", SEQ[(9 + j) % PERIOD], (j == PERIOD));
      end
      // R8: wrap lasts one cycle while holding at the seed.
      cyc(0, 0, 0, 0);
      chk("R8 single pulse", 4'b1010, 1'b0);

      // R7: zero seed becomes 0001, and the stored seed becomes 0001 too.
      cyc(0, 0, 1, 4'b0000);
      chk("R7 zero seed", 4'b0001, 1'b0);
      for (int j = 1; j <= PERIOD; j++) begin
         cyc(0, 1, 0, 0);
         if (j == 1 || j == PERIOD) chk("R7 stored seed 0001", SEQ[j % PERIOD], (j == PERIOD));
      end

      // R8: load of a seed equal to the current value gives no wrap.
      cyc(0, 0, 1, 4'b0001);
      chk("R8 no wrap on load", 4'b0001, 1'b0);

      // R1: reset while counting.
      cyc(0, 1, 1, 4'b1101);
      cyc(0, 1, 0, 0);
      chk("R3 from 1101", 4'b1001, 1'b0);
      cyc(1, 1, 0, 0);
      chk("R1 reset mid-run", 4'b0001, 1'b0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule